// File: doc/BRIEF.md
# Graphics DRAM Command and Register Decoder

This block sits on the command side of a synchronous graphics memory. It samples the chip-select, row strobe, column strobe, write enable and the special-function strobe, together with the address and data buses, on every rising clock edge. It recognises three commands: the no-operation, the mode register load and the special register load. From these it keeps the write-mode bit and the test-mode field of the mode register, and two data-width registers, one for the fill color and one for the per-bit write mask.

The special register load picks its target from two address bits. Address bit 6 selects the color register and address bit 5 selects the mask register. Either register is loaded from the data pins in the same edge. If both bits are set, the command is refused, neither register changes, and an illegal flag is raised for one cycle. All outputs come straight from registers, so a load becomes visible one clock after the edge that sampled it.

Top module: `gfx_cmd_decoder`

## Requirements
- R1: After a synchronous reset, color_q and mask_q are 0, single_write is 0, test_mode is 2'b00 and illegal is 0.
- R2: A special register load (cs_n=0, ras_n=0, cas_n=0, we_n=0, dsf=1) with addr[6]=1 and addr[5]=0 copies dq into color_q one clock later, and mask_q keeps its value.
- R3: A special register load with addr[5]=1 and addr[6]=0 copies dq into mask_q one clock later, and color_q keeps its value.
- R4: A special register load with addr[6]=1 and addr[5]=1 sets illegal to 1 in the next cycle only, and leaves color_q and mask_q unchanged.
- R5: A special register load with addr[6]=0 and addr[5]=0 changes no register, and illegal stays 0.
- R6: A mode register load (cs_n=0, ras_n=0, cas_n=0, we_n=0, dsf=0) sets single_write to addr[9] and test_mode to addr[8:7] one clock later. A value of 2'b00 is normal operation and any other value is a reserved test mode. color_q and mask_q are unchanged.
- R7: A no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1, any dsf) changes no output.
- R8: While cs_n=1, no command is decoded and no output changes, whatever the other inputs are.
- R9: Each special register load finishes in a single cycle, so loads on consecutive clocks all take effect, one per clock.
- R10: Any other strobe pattern with cs_n=0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function strobe, active high |
| addr | input | ADDR_W (10) | Address bus carrying the register control fields |
| dq | input | DATA_W (32) | Data bus carrying the register load value |
| color_q | output | DATA_W | Color register |
| mask_q | output | DATA_W | Mask register |
| single_write | output | 1 | 1 = burst read with single write, 0 = burst read and burst write |
| test_mode | output | 2 | Mode field; 00 is normal operation |
| illegal | output | 1 | One-cycle pulse after a refused special register load |

## Verification
A refused special register load and a good load can follow one another, so the illegal pulse from one command falls in the same cycle as the register update from the next. The bench provokes this with directed sequences: illegal followed by a color load, and a color load followed by a mask load followed by illegal. It checks that the flag drops on time while the right register takes the new data. The main sweep drives every combination of the five strobes against every value of address bits 9 to 5, with changing data, and compares all outputs after each edge with a model written from the requirements.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int BIT_SINGLE_WR = 9;
  localparam int BIT_TEST_HI   = 8;
  localparam int BIT_TEST_LO   = 7;
  localparam int BIT_SEL_COLOR = 6;
  localparam int BIT_SEL_MASK  = 5;
  localparam int MIN_ADDR_W    = 10;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_MODE_LD,
    CMD_SPEC_LD,
    CMD_OTHER
  } gcd_cmd_e;
endpackage

// File: rtl/gcd_cmd_decode.sv
module gcd_cmd_decode
  import gcd_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  input  logic     dsf,
  output gcd_cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique casez ({ras_n, cas_n, we_n, dsf})
        4'b111?: cmd = CMD_NOP;
        4'b0000: cmd = CMD_MODE_LD;
        4'b0001: cmd = CMD_SPEC_LD;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/gcd_mode_reg.sv
module gcd_mode_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_en,
  input  logic       wr_sel,
  input  logic [1:0] test_sel,
  output logic       single_write,
  output logic [1:0] test_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      single_write <= 1'b0;
      test_mode    <= 2'b00;
    end else if (load_en) begin
      single_write <= wr_sel;
      test_mode    <= test_sel;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!load_en) && $past(!rst)) |-> ($stable(single_write) && $stable(test_mode))); // R7
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(load_en) && $past(!rst)) |-> (single_write == $past(wr_sel) && test_mode == $past(test_sel))); // R6
endmodule

// File: rtl/gcd_special_regs.sv
module gcd_special_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              sel_color,
  input  logic              sel_mask,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              illegal_q
);
  logic color_we, mask_we, clash;

  always_comb begin
    clash    = load_en && sel_color && sel_mask;
    color_we = load_en && sel_color && !sel_mask;
    mask_we  = load_en && sel_mask && !sel_color;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      color_q   <= '0;
      mask_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= clash;
      if (color_we) color_q <= dq;
      if (mask_we)  mask_q  <= dq;
    end
  end

  AST_COLOR_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(load_en && sel_color && !sel_mask && !rst) |-> (color_q == $past(dq) && $stable(mask_q))); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(load_en && sel_mask && !sel_color && !rst) |-> (mask_q == $past(dq) && $stable(color_q))); // R3
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (illegal_q && $past(!rst)) |-> ($stable(color_q) && $stable(mask_q))); // R4
endmodule

// File: rtl/gfx_cmd_decoder.sv
module gfx_cmd_decoder
  import gcd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              single_write,
  output logic [1:0]        test_mode,
  output logic              illegal
);
  localparam int SPARE_W = BIT_SEL_MASK;

  gcd_cmd_e cmd;
  logic     unused_addr_bits;

  if (ADDR_W < MIN_ADDR_W) begin : g_bad_width
    initial $display("gfx_cmd_decoder: ADDR_W below %0d", MIN_ADDR_W);
  end

  if (ADDR_W > MIN_ADDR_W) begin : g_wide_addr
    assign unused_addr_bits = ^{addr[ADDR_W-1:MIN_ADDR_W], addr[SPARE_W-1:0]};
  end else begin : g_exact_addr
    assign unused_addr_bits = ^addr[SPARE_W-1:0];
  end

  gcd_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .dsf  (dsf),
    .cmd  (cmd)
  );

  gcd_mode_reg u_mode (
    .clk         (clk),
    .rst         (rst),
    .load_en     (cmd == CMD_MODE_LD),
    .wr_sel      (addr[BIT_SINGLE_WR]),
    .test_sel    (addr[BIT_TEST_HI:BIT_TEST_LO]),
    .single_write(single_write),
    .test_mode   (test_mode)
  );

  gcd_special_regs #(.DATA_W(DATA_W)) u_spec (
    .clk      (clk),
    .rst      (rst),
    .load_en  (cmd == CMD_SPEC_LD),
    .sel_color(addr[BIT_SEL_COLOR]),
    .sel_mask (addr[BIT_SEL_MASK]),
    .dq       (dq),
    .color_q  (color_q),
    .mask_q   (mask_q),
    .illegal_q(illegal)
  );

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n) && $past(!rst)) |-> ($stable(color_q) && $stable(mask_q) && $stable(single_write)
                                      && $stable(test_mode) && !illegal)); // R8
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(!cs_n && !ras_n && !cas_n && !we_n && dsf
                      && addr[BIT_SEL_COLOR] && addr[BIT_SEL_MASK])); // R4
endmodule

// File: tb/tb_gfx_cmd_decoder.sv
module tb_gfx_cmd_decoder;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic cs_n, ras_n, cas_n, we_n, dsf;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq;
  logic [DW-1:0] color_q, mask_q;
  logic single_write, illegal;
  logic [1:0] test_mode;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [DW-1:0] e_color, e_mask;
  logic e_sw, e_ill;
  logic [1:0] e_tm;

  always #10 clk = ~clk;

  gfx_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dsf(dsf), .addr(addr), .dq(dq),
    .color_q(color_q), .mask_q(mask_q), .single_write(single_write),
    .test_mode(test_mode), .illegal(illegal)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic check_all(input string req);
    checks++;
    if (color_q !== e_color || mask_q !== e_mask || single_write !== e_sw ||
        test_mode !== e_tm || illegal !== e_ill) begin
      errors++;
      $display("FAIL %s: got color=%h mask=%h sw=%b tm=%b ill=%b expected color=%h mask=%h sw=%b tm=%b ill=%b",
               req, color_q, mask_q, single_write, test_mode, illegal,
               e_color, e_mask, e_sw, e_tm, e_ill);
    end
  endtask

  // drive at negedge, one posedge, then check at the next negedge
  task automatic issue(input logic [4:0] s, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output string req);
    logic c6, c5;
    cs_n = s[4]; ras_n = s[3]; cas_n = s[2]; we_n = s[1]; dsf = s[0];
    addr = a; dq = d;
    c6 = a[6]; c5 = a[5];
    e_ill = 1'b0;
    if (s[4]) req = "R8";
    else if (s[3:1] == 3'b111) req = "R7";
    else if (s[3:0] == 4'b0000) begin
      req = "R6"; e_sw = a[9]; e_tm = a[8:7];
    end else if (s[3:0] == 4'b0001) begin
      if (c6 && c5) begin req = "R4"; e_ill = 1'b1; end
      else if (c6) begin req = "R2"; e_color = d; end
      else if (c5) begin req = "R3"; e_mask = d; end
      else req = "R5";
    end else req = "R10";
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic spec(input logic a6, input logic a5, input logic [DW-1:0] d, input string tag);
    string r;
    issue(5'b00001, {3'b000, a6, a5, 5'b00000}, d, r);
    check_all(tag);
  endtask

  initial begin
    string r;
    rst = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
    addr = '0; dq = '0;
    e_color = '0; e_mask = '0; e_sw = 1'b0; e_tm = 2'b00; e_ill = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst = 1'b0;

    // exhaustive sweep: all strobe patterns x all values of addr[9:5]
    for (int i = 0; i < 1024; i++) begin
      logic [4:0] s;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      s = i[9:5];
      a = {i[4:0], i[9:5] ^ 5'b10110};
      d = 32'h9E37_79B9 * (i + 7) ^ (i << 11);
      issue(s, a, d, r);
      check_all(r);
    end

    // back-to-back loads and illegal pulse next to a real load
    spec(1'b1, 1'b1, 32'hDEAD_0001, "R4");
    spec(1'b1, 1'b0, 32'hC0C0_1234, "R9");
    spec(1'b0, 1'b1, 32'h0F0F_5555, "R9");
    spec(1'b1, 1'b1, 32'hFFFF_FFFF, "R4");
    spec(1'b1, 1'b1, 32'h1111_1111, "R4");
    spec(1'b0, 1'b0, 32'h2222_2222, "R5");
    spec(1'b1, 1'b0, 32'hA5A5_A5A5, "R9");
    spec(1'b1, 1'b0, 32'h5A5A_5A5A, "R9");
    issue(5'b01110, 10'h3FF, 32'h7777_7777, r);
    check_all("R7");
    issue(5'b10000, 10'h3E0, 32'h3333_3333, r);
    check_all("R8");

    // reset mid-run restores every output
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e_color = '0; e_mask = '0; e_sw = 1'b0; e_tm = 2'b00; e_ill = 1'b0;
    check_all("R1");
    rst = 1'b0;
    report();
  end
endmodule